// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block turns a reference clock into a stream of one-cycle tick-enable pulses that average exactly 1 MHz. The reference can be any of several crystal frequencies. The ratio is programmable. A 16-bit ratio register holds two bytes, and each byte stores its count minus one. One byte gives a number of reference cycles, and the other gives how many ticks fall in that span. Reference frequencies such as 12.8, 16.8, 19.2 and 38.4 MHz therefore produce an exact average tick rate with no divider. The pulse spacing alternates between the floor and the ceiling of the ratio.

Every tick also advances a free-running microsecond counter. Software reads the counter through a small register port. A hold register can freeze the tick stream and the counter together. The ticks drive timer channels elsewhere on the chip.

Top module: `usec_prescaler`

## Requirements
- R1: After reset the tick output is low, the counter reads 0, the ratio register reads its reset value (0x000b by default) and the hold register reads 0.
- R2: The ratio register sits at offset 0x4. Bits [7:0] hold the reference cycles minus one (L) and bits [15:8] hold the ticks minus one (H). With H < L, every run of L+1 cycles that starts at a ratio write produces exactly H+1 ticks.
- R3: The tick output is high for a single cycle. The spacing between ticks is always floor or ceiling of (L+1)/(H+1) cycles, for example 12 or 13 for 0x043f and exactly 26 for 0x0019.
- R4: The counter reads at offset 0x0, zero-extended to 32 bits. It increases by one on the same clock edge that raises each tick, and at no other time.
- R5: The counter wraps from all ones to zero without any other effect.
- R6: When bit 0 of the hold register (offset 0x8) is 1, no ticks occur and both the counter and the fractional phase keep their values. After the bit is cleared, counting resumes from the saved phase.
- R7: A write to the ratio register restarts the phase at zero. The first tick after the write comes ceil((L+1)/(H+1)) cycles after the write edge, for example 12 cycles for 0x000b.
- R8: When H >= L, a tick occurs on every cycle that is not held.
- R9: A write to the counter offset has no effect on the count. A read from an unmapped offset returns 0.
- R10: The ratio register reads back all 16 bits that were written, and the hold register reads back bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| tick_o | output | 1 | One-cycle microsecond tick enable |

## Verification
The hardest case to reach is counter wraparound. A 32-bit count at one tick per microsecond does not wrap within any practical run. The bench therefore adds a second instance with an 8-bit counter and a reset ratio of 0x0000, which ticks on every cycle. Its read port is watched until it shows 0xFF, and the next cycle must show 0.

Resuming from the saved phase after a hold is hard to see from the ports alone. The bench checks it by freezing the block one cycle after a ratio write and then measuring the delay to the first tick after release.

// File: rtl/usec_pkg.sv
// Shared constants for the microsecond prescaler: register offsets and
// default field widths. Assumes a 4-bit byte-offset register port.
package usec_pkg;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 32;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RATIO = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_HOLD  = 4'h8;
endpackage

// File: rtl/usec_regs.sv
// Register port for the prescaler: stores the ratio and hold bit, flags a
// ratio write, and multiplexes read data. Assumes CNT_W <= DATA_W and
// 2*BYTE_W <= DATA_W; reads are combinational on addr.
module usec_regs
    import usec_pkg::*;
#(
    parameter int          DW          = DATA_W,
    parameter int          BW          = BYTE_W,
    parameter int          CW          = CNT_W,
    parameter logic [15:0] RESET_RATIO = 16'h000b
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [CW-1:0]     count,
    output logic [BW-1:0]     cyc_m1,
    output logic [BW-1:0]     tck_m1,
    output logic              hold,
    output logic              ratio_wr,
    output logic [DW-1:0]     rd_data
);
    localparam int RW = 2 * BW;

    logic [RW-1:0] ratio_q;
    logic          hold_q;

    wire unused_wdata = ^wr_data[DW-1:RW];

    // Decode a write aimed at the ratio register.
    assign ratio_wr = wr_en && (addr == OFS_RATIO);

    // Hold the ratio and hold bit under the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= RESET_RATIO[RW-1:0];
            hold_q  <= 1'b0;
        end else if (wr_en) begin
            if (addr == OFS_RATIO) ratio_q <= wr_data[RW-1:0];
            if (addr == OFS_HOLD)  hold_q  <= wr_data[0];
        end
    end

    assign cyc_m1 = ratio_q[BW-1:0];
    assign tck_m1 = ratio_q[RW-1:BW];
    assign hold   = hold_q;

    // Select read data; unmapped offsets read as zero.
    always_comb begin
        rd_data = '0;
        case (addr)
            OFS_COUNT: rd_data = DW'(count);
            OFS_RATIO: rd_data = DW'(ratio_q);
            OFS_HOLD:  rd_data = DW'(hold_q);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/usec_frac_accum.sv
// Fractional phase accumulator. Each active cycle adds (tck_m1+1) to the
// phase; when the phase reaches (cyc_m1+1) it fires and subtracts that
// limit. A ratio of one or more ticks per cycle fires every cycle. Assumes
// clear coincides with a new ratio taking effect.
module usec_frac_accum #(
    parameter int BW = 8,
    localparam int AW = BW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hold,
    input  logic [BW-1:0] cyc_m1,
    input  logic [BW-1:0] tck_m1,
    output logic          fire,
    output logic          tick,
    output logic [AW-1:0] phase
);
    logic [AW-1:0] phase_q;
    logic [AW-1:0] step;
    logic [AW-1:0] limit;
    logic [AW-1:0] sum;
    logic          saturate;
    logic          tick_q;

    // Form the step, the wrap limit and the candidate phase.
    always_comb begin
        step     = AW'(tck_m1) + AW'(1);
        limit    = AW'(cyc_m1) + AW'(1);
        sum      = phase_q + step;
        saturate = (tck_m1 >= cyc_m1);
        fire     = !clear && !hold && (saturate || (sum >= limit));
    end

    // Advance the phase and register the tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else if (clear) begin
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else if (hold) begin
            tick_q  <= 1'b0;
        end else if (saturate) begin
            phase_q <= '0;
            tick_q  <= 1'b1;
        end else if (sum >= limit) begin
            phase_q <= sum - limit;
            tick_q  <= 1'b1;
        end else begin
            phase_q <= sum;
            tick_q  <= 1'b0;
        end
    end

    assign tick  = tick_q;
    assign phase = phase_q;
endmodule

// File: rtl/usec_counter.sv
// Free-running microsecond counter; adds one per accepted tick and wraps
// silently at 2**CW.
module usec_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    logic [CW-1:0] count_q;

    // Count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)   count_q <= '0;
        else if (inc) count_q <= count_q + CW'(1);
    end

    assign count = count_q;
endmodule

// File: rtl/usec_prescaler.sv
// Top of the microsecond prescaler: register port, fractional accumulator
// and tick counter. Assumes a single clock domain; tick_o is an enable
// pulse for logic on the same clock.
module usec_prescaler
    import usec_pkg::*;
#(
    parameter int          DW          = DATA_W,
    parameter int          BW          = BYTE_W,
    parameter int          CW          = CNT_W,
    parameter logic [15:0] RESET_RATIO = 16'h000b
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              tick_o
);
    localparam int AW = BW + 2;

    logic [BW-1:0] cyc_m1;
    logic [BW-1:0] tck_m1;
    logic          hold;
    logic          ratio_wr;
    logic          fire;
    logic [AW-1:0] phase;
    logic [CW-1:0] count;

    usec_regs #(
        .DW(DW), .BW(BW), .CW(CW), .RESET_RATIO(RESET_RATIO)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .count(count), .cyc_m1(cyc_m1),
        .tck_m1(tck_m1), .hold(hold), .ratio_wr(ratio_wr),
        .rd_data(rd_data)
    );

    usec_frac_accum #(.BW(BW)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(ratio_wr), .hold(hold),
        .cyc_m1(cyc_m1), .tck_m1(tck_m1), .fire(fire),
        .tick(tick_o), .phase(phase)
    );

    usec_counter #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(fire), .count(count)
    );
endmodule

// File: rtl/usec_prescaler_chk.sv
// Assertion checker for usec_prescaler, attached by bind. Watches the
// tick, counter, phase and register state across cycles.
module usec_prescaler_chk #(
    parameter int BW = 8,
    parameter int CW = 32,
    localparam int AW = BW + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [CW-1:0] count,
    input logic          hold,
    input logic [AW-1:0] phase,
    input logic [BW-1:0] cyc_m1,
    input logic [BW-1:0] tck_m1,
    input logic          ratio_wr
);
    logic seen;

    // Mark that at least one cycle out of reset has been sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && tick) |-> (count == CW'($past(count) + CW'(1))));

    // R4
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !tick) |-> (count == $past(count)));

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(hold)) |-> !tick);

    // R2
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= AW'(cyc_m1));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(ratio_wr)) |-> (phase == '0 && !tick));

    // R8
    every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(tck_m1 >= cyc_m1 && !hold && !ratio_wr)) |-> tick);
endmodule

bind usec_prescaler usec_prescaler_chk #(.BW(BW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_o), .count(count), .hold(hold),
    .phase(phase), .cyc_m1(cyc_m1), .tck_m1(tck_m1), .ratio_wr(ratio_wr)
);

// File: tb/usec_prescaler_test.sv
module usec_prescaler_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick_o;
    logic [31:0] rd_data_w;
    logic        tick_w;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    usec_prescaler uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .tick_o(tick_o)
    );

    usec_prescaler #(.CW(8), .RESET_RATIO(16'h0000)) uut_wrap (
        .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .addr(4'h0),
        .wr_data(32'h0), .rd_data(rd_data_w), .tick_o(tick_w)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write one register; called at a falling edge, returns at the next one.
    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'h0; wr_data = '0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rd_data;
        addr = 4'h0;
        #0.5;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        check(tick_o == 1'b0, "R1 tick", tick_o, 0);
        reg_read(4'h0, v); check(v == 0, "R1 count", v, 0);
        reg_read(4'h4, v); check(v == 32'h000b, "R1 ratio", v, 32'h000b);
        reg_read(4'h8, v); check(v == 0, "R1 hold", v, 0);
    endtask

    // R7: delay from a ratio write to the first tick.
    task automatic t_restart(input logic [15:0] ratio, input int exp_delay);
        int n = 0;
        reg_write(4'h4, {16'h0, ratio});
        for (int i = 1; i <= 600; i++) begin
            @(negedge clk);
            if (tick_o) begin n = i; break; end
        end
        check(n == exp_delay, "R7 first tick delay", n, exp_delay);
    endtask

    // R2/R3/R4: tick total, spacing and counter over a window.
    task automatic t_ratio(input logic [15:0] ratio, input int cycles,
                           input int exp_ticks, input int gmin, input int gmax);
        logic [31:0] c0, c1;
        int ticks = 0, last = 0, bad_gap = 0, doubles = 0;
        bit prev = 1'b0;
        reg_write(4'h4, {16'h0, ratio});
        reg_read(4'h0, c0);
        for (int i = 1; i <= cycles; i++) begin
            @(negedge clk);
            if (tick_o) begin
                if (ticks > 0 && (i - last < gmin || i - last > gmax)) bad_gap++;
                if (prev && gmin > 1) doubles++;
                ticks++;
                last = i;
            end
            prev = tick_o;
        end
        reg_read(4'h0, c1);
        check(ticks == exp_ticks, "R2 tick total", ticks, exp_ticks);
        check(bad_gap == 0, "R3 tick spacing", bad_gap, 0);
        check(doubles == 0, "R3 single-cycle pulse", doubles, 0);
        check(c1 - c0 == exp_ticks, "R4 counter advance", c1 - c0, exp_ticks);
    endtask

    // R6: hold freezes ticks, counter and phase.
    task automatic t_hold();
        logic [31:0] c0, c1, v;
        int seen_tick = 0, n = 0;
        reg_write(4'h4, 32'h000b);
        reg_write(4'h8, 32'h1);
        reg_read(4'h8, v); check(v == 1, "R10 hold readback", v, 1);
        reg_read(4'h0, c0);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tick_o) seen_tick++;
        end
        reg_read(4'h0, c1);
        check(seen_tick == 0, "R6 no tick while held", seen_tick, 0);
        check(c1 == c0, "R6 counter held", c1, c0);
        reg_write(4'h0, 32'h55);
        @(negedge clk);
        reg_read(4'h0, v); check(v == c0, "R9 counter write ignored", v, c0);
        reg_read(4'hc, v); check(v == 0, "R9 unmapped read", v, 0);
        reg_write(4'h8, 32'h0);
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (tick_o) begin n = i; break; end
        end
        check(n == 11, "R6 phase resumes", n, 11);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        reg_write(4'h4, 32'hdead_a5c3);
        reg_read(4'h4, v); check(v == 32'h0000_a5c3, "R10 ratio readback", v, 32'ha5c3);
    endtask

    // R5: small-counter instance ticks every cycle and wraps.
    task automatic t_wrap();
        int found = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (rd_data_w == 32'hff) begin found = 1; break; end
        end
        check(found == 1, "R5 reached all ones", found, 1);
        @(negedge clk);
        check(rd_data_w == 0, "R5 wrap to zero", rd_data_w, 0);
        @(negedge clk);
        check(rd_data_w == 1, "R5 counts on after wrap", rd_data_w, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_restart(16'h000b, 12);
        t_restart(16'h043f, 13);
        t_ratio(16'h043f, 640, 50, 12, 13);
        t_ratio(16'h0453, 840, 50, 16, 17);
        t_ratio(16'h0019, 520, 20, 26, 26);
        t_ratio(16'h0000, 20, 20, 1, 1);  // R8 every cycle
        t_ratio(16'h0707, 20, 20, 1, 1);  // R8 equal fields
        t_hold();
        t_readback();
        t_wrap();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule